// File: doc/BRIEF.md
# Received PAUSE Frame Responder

This block sits on the receive side of one Ethernet port and looks for MAC Control PAUSE requests from the link partner. It follows each incoming frame byte by byte. It keeps running verdicts on the destination address and on the control header, and it captures the requested pause time. Only when the frame has ended, with good status and at least the minimum length, does it decide whether to act on it.

When a frame is accepted, the block turns its pause time into a stall of the local transmitter. The hold is measured in quanta of 512 bit times, counted on a bit-time enable. If a frame is going out when the request arrives, the hold waits until that frame is done. A later request replaces the one in force. A request of zero, or switching receive flow control off, releases the transmitter at once.

Top module: `pause_rx_responder`

## Requirements
- R1: While reset is high, and on the first edge after it, tx_hold is low.
- R2: The destination address, first six bytes with the most significant byte first on the wire, must equal 01-80-C2-00-00-01 or station_addr (station_addr[47:40] is the first byte). Any other destination is ignored.
- R3: Bytes 12-13 must be 0x88,0x08 and bytes 14-15 must be 0x00,0x01, where byte 0 is the byte flagged by rx_sof. Bytes 16-17 are the pause time, high byte first. A frame with any other header is ignored.
- R4: A frame is acted on only if rx_good is high with the rx_eof byte and the frame holds at least MIN_FRAME_BYTES (default 64) bytes, counting rx_sof to rx_eof inclusive. A new rx_sof drops any unfinished frame and starts parsing again.
- R5: With tx_busy low, an accepted frame with a nonzero pause time raises tx_hold on the second rising edge after the edge that samples its rx_eof byte.
- R6: tx_hold stays high for exactly pause_time × BITS_PER_QUANTUM bit_tick pulses. While bit_tick is low the hold does not advance.
- R7: If tx_busy is high when the request arrives, tx_hold stays low until the first edge that samples tx_busy low, and goes high on that edge.
- R8: An accepted frame that arrives while tx_hold is high reloads the count with its pause time and restarts the current quantum.
- R9: An accepted frame with pause time zero drives tx_hold low on the second edge after its rx_eof byte.
- R10: While fc_rx_en is low, no frame is acted on, and tx_hold is low from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | rx_data carries a frame byte |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_good | input | 1 | Frame status with rx_eof (CRC and length good) |
| station_addr | input | 48 | Own unicast address |
| fc_rx_en | input | 1 | Honour received pause requests |
| tx_busy | input | 1 | Transmitter is sending a frame |
| bit_tick | input | 1 | One pulse per bit time |
| tx_hold | output | 1 | Stall transmitter before its next frame |

## Verification
A wrong address or header verdict appears as a hold that starts when it should not, or fails to start. This is visible two cycles after the last byte of the frame. A wrong count or prescaler phase shows only at release, where the hold length differs from pause_time × 512 ticks by at least one cycle. The bench therefore measures every hold from its first to its last cycle. A wrong pending state shows up while tx_busy is still high, as a hold that starts early, or as no hold in the cycle after tx_busy falls.

// File: rtl/pause_rx_pkg.sv
package pause_rx_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
    localparam int QUANTA_W   = 16;

    // Frame layout, byte offsets counted from the start-of-frame byte
    localparam int TYPE_OFS = 12;
    localparam int TIME_OFS = 16;
    localparam int HDR_END  = 18;

    localparam logic [ADDR_W-1:0] PAUSE_MC_ADDR = 48'h0180_C200_0001;
    localparam logic [15:0]       MAC_CTRL_TYPE = 16'h8808;
    localparam logic [15:0]       PAUSE_OPCODE  = 16'h0001;
    localparam logic [31:0]       HDR_PATTERN   = {MAC_CTRL_TYPE, PAUSE_OPCODE};

    typedef enum logic [1:0] {
        HS_IDLE    = 2'd0,
        HS_PENDING = 2'd1,
        HS_PAUSED  = 2'd2
    } hold_state_e;

    typedef struct packed {
        logic                valid;
        logic [QUANTA_W-1:0] quanta;
    } pause_req_t;

    // Compare one of the four type/opcode bytes against the expected pattern
    function automatic logic hdr_byte_match(input logic [BYTE_W-1:0] d,
                                            input logic [1:0]        pos);
        logic [BYTE_W-1:0] want;
        want = HDR_PATTERN[BYTE_W*(3-int'(pos)) +: BYTE_W];
        return d == want;
    endfunction

endpackage

// File: rtl/pause_da_match.sv
module pause_da_match
    import pause_rx_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 byte_en,
    input  logic                 first,
    input  logic [IDX_W-1:0]     idx,
    input  logic [BYTE_W-1:0]    data,
    input  logic [ADDR_W-1:0]    station,
    output logic                 mc_hit,
    output logic                 st_hit
);

    logic [ADDR_BYTES-1:0] mc_eq;
    logic [ADDR_BYTES-1:0] st_eq;

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr_byte
        localparam int SH = BYTE_W * (ADDR_BYTES - 1 - g);
        assign mc_eq[g] = (data == PAUSE_MC_ADDR[SH +: BYTE_W]);
        assign st_eq[g] = (data == station[SH +: BYTE_W]);
    end

    logic in_da;
    logic mc_sel;
    logic st_sel;

    always_comb begin
        in_da  = 1'b0;
        mc_sel = 1'b0;
        st_sel = 1'b0;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (idx == IDX_W'(k)) begin
                in_da  = 1'b1;
                mc_sel = mc_eq[k];
                st_sel = st_eq[k];
            end
        end
    end

    logic mc_q;
    logic st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mc_q <= 1'b0;
            st_q <= 1'b0;
        end else if (byte_en && (first || in_da)) begin
            mc_q <= (first ? 1'b1 : mc_q) & mc_sel;
            st_q <= (first ? 1'b1 : st_q) & st_sel;
        end
    end

    assign mc_hit = mc_q;
    assign st_hit = st_q;

endmodule

// File: rtl/pause_frame_parser.sv
module pause_frame_parser
    import pause_rx_pkg::*;
#(
    parameter int MIN_FRAME_BYTES = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_valid,
    input  logic [BYTE_W-1:0]  rx_data,
    input  logic               rx_sof,
    input  logic               rx_eof,
    input  logic               rx_good,
    input  logic [ADDR_W-1:0]  station,
    input  logic               fc_en,
    output pause_req_t         req_o
);

    localparam int LEN_FLOOR = (MIN_FRAME_BYTES > HDR_END) ? MIN_FRAME_BYTES : HDR_END;
    localparam int IDX_W     = $clog2(LEN_FLOOR + 1);

    localparam logic [IDX_W-1:0] IX_TYPE = IDX_W'(TYPE_OFS);
    localparam logic [IDX_W-1:0] IX_TIME = IDX_W'(TIME_OFS);
    localparam logic [IDX_W-1:0] IX_TLO  = IDX_W'(TIME_OFS + 1);
    localparam logic [IDX_W-1:0] IX_LAST = IDX_W'(LEN_FLOOR - 1);
    localparam logic [IDX_W-1:0] IX_SAT  = IDX_W'(LEN_FLOOR);

    logic                in_frame_q;
    logic [IDX_W-1:0]    idx_q;
    logic                hdr_ok_q;
    logic [QUANTA_W-1:0] time_q;

    logic             byte_take;
    logic [IDX_W-1:0] cur_idx;

    assign byte_take = rx_valid && (rx_sof || in_frame_q);
    assign cur_idx   = rx_sof ? '0 : idx_q;

    logic mc_hit;
    logic st_hit;

    pause_da_match #(.IDX_W(IDX_W)) u_da (
        .clk     (clk),
        .rst     (rst),
        .byte_en (byte_take),
        .first   (rx_sof),
        .idx     (cur_idx),
        .data    (rx_data),
        .station (station),
        .mc_hit  (mc_hit),
        .st_hit  (st_hit)
    );

    logic                in_hdr;
    logic [1:0]          hdr_pos;
    logic                hdr_ok_d;
    logic [QUANTA_W-1:0] time_now;
    logic                len_ok;
    pause_req_t          req_d;

    always_comb begin
        in_hdr   = (cur_idx >= IX_TYPE) && (cur_idx < IX_TIME);
        hdr_pos  = 2'(cur_idx - IX_TYPE);
        hdr_ok_d = rx_sof ? 1'b1 : hdr_ok_q;
        if (in_hdr) begin
            hdr_ok_d = hdr_ok_d & hdr_byte_match(rx_data, hdr_pos);
        end
        // The low pause-time byte may be the closing byte when the floor is 18
        time_now = (cur_idx == IX_TLO) ? {time_q[QUANTA_W-1:BYTE_W], rx_data} : time_q;
        len_ok   = (cur_idx >= IX_LAST);
        req_d.valid  = byte_take && rx_eof && rx_good && fc_en && len_ok
                       && hdr_ok_q && (mc_hit || st_hit);
        req_d.quanta = time_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            idx_q      <= '0;
            hdr_ok_q   <= 1'b0;
            time_q     <= '0;
            req_o      <= '0;
        end else begin
            req_o <= req_d;
            if (byte_take) begin
                in_frame_q <= !rx_eof;
                idx_q      <= (cur_idx == IX_SAT) ? cur_idx : cur_idx + 1'b1;
                hdr_ok_q   <= hdr_ok_d;
                if (cur_idx == IX_TIME) time_q[QUANTA_W-1:BYTE_W] <= rx_data;
                if (cur_idx == IX_TLO)  time_q[BYTE_W-1:0]        <= rx_data;
            end
        end
    end

endmodule

// File: rtl/pause_quantum_prescaler.sv
module pause_quantum_prescaler #(
    parameter int BITS_PER_QUANTUM = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    input  logic bit_tick,
    output logic quantum_stb
);

    localparam int PRE_W = (BITS_PER_QUANTUM > 1) ? $clog2(BITS_PER_QUANTUM) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(BITS_PER_QUANTUM - 1);

    logic [PRE_W-1:0] pre_q;

    assign quantum_stb = run && !restart && bit_tick && (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            pre_q <= '0;
        end else if (bit_tick) begin
            pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/pause_hold_engine.sv
module pause_hold_engine
    import pause_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pause_req_t req_i,
    input  logic       fc_en,
    input  logic       tx_busy,
    input  logic       quantum_stb,
    output logic       load_o,
    output logic       pending_o,
    output logic       hold_o
);

    hold_state_e         state_q, state_d;
    logic [QUANTA_W-1:0] cnt_q, cnt_d;
    logic [QUANTA_W-1:0] pend_q, pend_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pend_d  = pend_q;
        load_o  = 1'b0;
        if (!fc_en) begin
            state_d = HS_IDLE;
            cnt_d   = '0;
        end else if (req_i.valid) begin
            if (req_i.quanta == '0) begin
                state_d = HS_IDLE;
                cnt_d   = '0;
            end else if (state_q == HS_PAUSED || !tx_busy) begin
                state_d = HS_PAUSED;
                cnt_d   = req_i.quanta;
                load_o  = 1'b1;
            end else begin
                state_d = HS_PENDING;
                pend_d  = req_i.quanta;
            end
        end else begin
            unique case (state_q)
                HS_PENDING: begin
                    if (!tx_busy) begin
                        state_d = HS_PAUSED;
                        cnt_d   = pend_q;
                        load_o  = 1'b1;
                    end
                end
                HS_PAUSED: begin
                    if (quantum_stb) begin
                        if (cnt_q <= 1) begin
                            state_d = HS_IDLE;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q - 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HS_IDLE;
            cnt_q   <= '0;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pend_q  <= pend_d;
        end
    end

    assign hold_o    = (state_q == HS_PAUSED);
    assign pending_o = (state_q == HS_PENDING);

endmodule

// File: rtl/pause_rx_responder.sv
module pause_rx_responder
    import pause_rx_pkg::*;
#(
    parameter int MIN_FRAME_BYTES  = 64,
    parameter int BITS_PER_QUANTUM = 512
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_valid,
    input  logic [BYTE_W-1:0]  rx_data,
    input  logic               rx_sof,
    input  logic               rx_eof,
    input  logic               rx_good,
    input  logic [ADDR_W-1:0]  station_addr,
    input  logic               fc_rx_en,
    input  logic               tx_busy,
    input  logic               bit_tick,
    output logic               tx_hold
);

    pause_req_t req;
    logic       load;
    logic       pending;
    logic       quantum_stb;

    pause_frame_parser #(.MIN_FRAME_BYTES(MIN_FRAME_BYTES)) u_parser (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_sof   (rx_sof),
        .rx_eof   (rx_eof),
        .rx_good  (rx_good),
        .station  (station_addr),
        .fc_en    (fc_rx_en),
        .req_o    (req)
    );

    pause_quantum_prescaler #(.BITS_PER_QUANTUM(BITS_PER_QUANTUM)) u_pre (
        .clk         (clk),
        .rst         (rst),
        .run         (tx_hold),
        .restart     (load),
        .bit_tick    (bit_tick),
        .quantum_stb (quantum_stb)
    );

    pause_hold_engine u_engine (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req),
        .fc_en       (fc_rx_en),
        .tx_busy     (tx_busy),
        .quantum_stb (quantum_stb),
        .load_o      (load),
        .pending_o   (pending),
        .hold_o      (tx_hold)
    );

endmodule

// File: rtl/pause_rx_checker.sv
module pause_rx_checker (
    input logic clk,
    input logic rst,
    input logic fc_rx_en,
    input logic tx_busy,
    input logic bit_tick,
    input logic tx_hold,
    input logic req_valid,
    input logic req_zero,
    input logic pend
);

    p_reset_low_r1: assert property (@(posedge clk) rst |=> !tx_hold);

    p_rise_cause_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_hold) |-> ($past(req_valid) || $past(pend)));

    p_stall_no_tick_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_hold && !bit_tick && fc_rx_en && !(req_valid && req_zero)) |=> tx_hold);

    p_defer_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (!tx_hold && tx_busy) |=> !tx_hold);

    p_zero_release_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_zero) |=> !tx_hold);

    p_fc_off_r10: assert property (@(posedge clk) disable iff (rst)
        !fc_rx_en |=> !tx_hold);

endmodule

bind pause_rx_responder pause_rx_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .fc_rx_en  (fc_rx_en),
    .tx_busy   (tx_busy),
    .bit_tick  (bit_tick),
    .tx_hold   (tx_hold),
    .req_valid (req.valid),
    .req_zero  (req.quanta == 16'd0),
    .pend      (pending)
);

// File: tb/pause_rx_responder_tb.sv
module pause_rx_responder_tb;

    localparam int QB = 512;
    localparam logic [47:0] MC  = 48'h0180_C200_0001;
    localparam logic [47:0] STA = 48'h001B_213C_4D5E;
    localparam logic [15:0] TY  = 16'h8808;
    localparam logic [15:0] OP  = 16'h0001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_sof = 1'b0;
    logic        rx_eof = 1'b0;
    logic        rx_good = 1'b0;
    logic        fc_rx_en = 1'b1;
    logic        tx_busy = 1'b0;
    logic        bit_tick = 1'b1;
    logic        tx_hold;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pause_rx_responder u_dut (
        .clk          (clk),
        .rst          (rst),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_sof       (rx_sof),
        .rx_eof       (rx_eof),
        .rx_good      (rx_good),
        .station_addr (STA),
        .fc_rx_en     (fc_rx_en),
        .tx_busy      (tx_busy),
        .bit_tick     (bit_tick),
        .tx_hold      (tx_hold)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(input int i, input logic [47:0] da,
                                         input logic [15:0] ty, input logic [15:0] op,
                                         input logic [15:0] pt);
        if (i < 6)   return da[47-8*i -: 8];
        if (i < 12)  return 8'(8'h20 + i);
        if (i == 12) return ty[15:8];
        if (i == 13) return ty[7:0];
        if (i == 14) return op[15:8];
        if (i == 15) return op[7:0];
        if (i == 16) return pt[15:8];
        if (i == 17) return pt[7:0];
        return 8'(i * 7);
    endfunction

    function automatic bit exp_accept(input logic [47:0] da, input logic [15:0] ty,
                                      input logic [15:0] op, input int len,
                                      input logic good);
        return ((da == MC) || (da == STA)) && (ty == TY) && (op == OP)
               && (len >= 64) && good;
    endfunction

    // Drive a frame; a0/a1 are tx_hold one and two cycles after the eof edge
    task automatic send_frame(input logic [47:0] da, input logic [15:0] ty,
                              input logic [15:0] op, input logic [15:0] pt,
                              input int len, input logic good,
                              output logic a0, output logic a1);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = fbyte(i, da, ty, op, pt);
            rx_sof   = (i == 0);
            rx_eof   = (i == len - 1);
            rx_good  = (i == len - 1) ? good : 1'b0;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_good = 1'b0;
        a0 = tx_hold;
        @(negedge clk);
        a1 = tx_hold;
    endtask

    task automatic send_partial(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = fbyte(i, MC, TY, OP, 16'd9);
            rx_sof   = (i == 0);
            rx_eof   = 1'b0;
        end
    endtask

    // Counts high samples, including the one already taken
    task automatic measure(input logic first, output int n);
        n = first ? 1 : 0;
        if (first) begin
            for (int k = 0; k < 40000; k++) begin
                @(negedge clk);
                if (tx_hold) n++;
                else break;
            end
        end
    endtask

    task automatic expect_quiet(input string tag, input int cyc);
        int highs = 0;
        for (int k = 0; k < cyc; k++) begin
            @(negedge clk);
            if (tx_hold) highs++;
        end
        chk(tag, highs, 0);
    endtask

    // Frame from idle with tx_busy low
    task automatic idle_case(input string tag, input logic [47:0] da,
                             input logic [15:0] ty, input logic [15:0] op,
                             input logic [15:0] pt, input int len, input logic good);
        logic a0, a1;
        int   n;
        bit   on;
        on = exp_accept(da, ty, op, len, good) && fc_rx_en && (pt != 0);
        send_frame(da, ty, op, pt, len, good, a0, a1);
        chk({tag, " R5 onset-1"}, a0, 0);
        chk({tag, " R5 onset"}, a1, on);
        if (on) begin
            measure(a1, n);
            chk({tag, " R6 length"}, n, QB * int'(pt));
        end else begin
            expect_quiet({tag, " quiet"}, 4);
        end
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic a0, a1;
        int   n;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        chk("R1 in reset", tx_hold, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", tx_hold, 0);

        // R2 address acceptance
        idle_case("R2 multicast", MC, TY, OP, 16'd3, 64, 1'b1);
        idle_case("R2 station", STA, TY, OP, 16'd1, 72, 1'b1);
        idle_case("R2 foreign da", STA ^ 48'h0000_0100_0000, TY, OP, 16'd2, 64, 1'b1);
        idle_case("R2 near multicast", MC ^ 48'h1, TY, OP, 16'd2, 64, 1'b1);

        // R3 header
        idle_case("R3 bad type", MC, 16'h0800, OP, 16'd2, 64, 1'b1);
        idle_case("R3 bad opcode", MC, TY, 16'h0101, 16'd2, 64, 1'b1);
        idle_case("R3 pause time msb", MC, TY, OP, 16'h0002, 64, 1'b1);

        // R4 status, length, restart
        idle_case("R4 bad status", MC, TY, OP, 16'd2, 64, 1'b0);
        idle_case("R4 short 63", MC, TY, OP, 16'd2, 63, 1'b1);
        send_partial(30);
        idle_case("R4 restart on sof", STA, TY, OP, 16'd1, 64, 1'b1);

        // R7 deferral behind a frame in flight
        @(negedge clk); tx_busy = 1'b1;
        send_frame(MC, TY, OP, 16'd2, 64, 1'b1, a0, a1);
        chk("R7 held off at onset", a1, 0);
        expect_quiet("R7 held off while busy", 20);
        tx_busy = 1'b0;
        @(negedge clk);
        chk("R7 starts after busy", tx_hold, 1);
        measure(tx_hold, n);
        chk("R7 R6 deferred length", n, QB * 2);

        // R8 reload while paused
        send_frame(MC, TY, OP, 16'd8, 64, 1'b1, a0, a1);
        chk("R8 first pause", a1, 1);
        repeat (300) @(negedge clk);
        send_frame(STA, TY, OP, 16'd2, 64, 1'b1, a0, a1);
        chk("R8 still held", a1, 1);
        measure(a1, n);
        chk("R8 reload length", n, QB * 2);

        // R9 zero releases
        send_frame(MC, TY, OP, 16'd6, 64, 1'b1, a0, a1);
        repeat (100) @(negedge clk);
        send_frame(MC, TY, OP, 16'd0, 64, 1'b1, a0, a1);
        chk("R9 held before zero acts", a0, 1);
        chk("R9 released by zero", a1, 0);
        expect_quiet("R9 stays released", 4);

        // R10 flow control off
        send_frame(MC, TY, OP, 16'd5, 64, 1'b1, a0, a1);
        chk("R10 paused", a1, 1);
        fc_rx_en = 1'b0;
        @(negedge clk);
        chk("R10 release on disable", tx_hold, 0);
        idle_case("R10 ignored while off", MC, TY, OP, 16'd3, 64, 1'b1);
        fc_rx_en = 1'b1;
        @(negedge clk);

        // R6 stall without bit_tick
        send_frame(MC, TY, OP, 16'd1, 64, 1'b1, a0, a1);
        chk("R6 stall onset", a1, 1);
        bit_tick = 1'b0;
        repeat (2000) @(negedge clk);
        chk("R6 frozen without tick", tx_hold, 1);
        bit_tick = 1'b1;
        n = 0;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (tx_hold) n++;
            else break;
        end
        // ticks on the next 512 edges; the last one clears the hold
        chk("R6 remaining after stall", n, QB - 1);

        // Random mix
        for (int t = 0; t < 30; t++) begin
            logic [47:0] da;
            logic [15:0] ty, op, pt;
            int          len, sel;
            logic        good;
            sel  = int'($urandom_range(0, 3));
            da   = (sel == 0) ? MC : (sel == 1) ? STA :
                   (sel == 2) ? (STA ^ (48'h1 << (8 * $urandom_range(0, 5))))
                              : (MC ^ (48'h80 << (8 * $urandom_range(0, 5))));
            ty   = ($urandom_range(0, 9) < 8) ? TY : 16'h8809;
            op   = ($urandom_range(0, 9) < 8) ? OP : 16'h0002;
            pt   = 16'($urandom_range(0, 3));
            case ($urandom_range(0, 4))
                0: len = 40;
                1: len = 63;
                2: len = 64;
                3: len = 70;
                default: len = 100;
            endcase
            good = ($urandom_range(0, 19) < 17);
            idle_case("R2 R3 R4 random", da, ty, op, pt, len, good);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule